// File: doc/BRIEF.md
# MDIO Management Master (Clause 22)

This block is a register-programmed management master for the two-wire PHY management bus. Software sets an enable bit and a clock divider, then starts a single read or write frame by writing a packed access word with its start flag set. The block generates the management clock, shifts out the preamble, start, opcode, PHY address and register number, and then either drives the data or releases the data line to capture the PHY's reply. The start flag stays set while the frame runs and clears by itself at the end. Software polls it, then reads back an acknowledge flag and the data.

A manual mode lets software take over the clock, the data output and the output enable directly, and read the data pin level, so that it can bit-bang the bus. Entering manual mode, or clearing the enable bit, stops any frame in progress. All pin outputs come from registers and follow the internal state one functional clock later.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word (offset 0) reads 0x800000FF: idle flag bit 31 = 1, enable bit 30 = 0, divider bits 15:0 = 0x00FF. The access word (offset 1) reads 0.
- R2: While a frame runs, one bus clock period lasts divider+1 functional clocks. Divider values below 3 act as 3. The bus clock rests high when no frame runs.
- R3: The access word holds start flag bit 31, write flag bit 30 (0 = read), acknowledge bit 29, register number 25:21, PHY address 20:16 and data 15:0. A write to it with bit 31 set, while enabled, not in manual mode and not busy, starts a frame. Bit 31 then reads 1 and control bit 31 reads 0 until the frame ends, when both flip back.
- R4: Each frame sends, in order and MSB first: 32 ones, start bits 01, opcode 10 (read) or 01 (write), the 5-bit PHY address and the 5-bit register number. The output enable is high for all of these 46 bits.
- R5: A write frame then drives the turnaround bits 1, 0 and the 16 data bits MSB first, with the output enable high for all 64 bits.
- R6: A read frame releases the output enable for bits 46 to 63. It samples the data pin on the rising clock of bit 47, where a low level sets the acknowledge bit, and captures bits 48 to 63 as data MSB first.
- R7: A read without acknowledge still issues all 64 clocks, leaves the acknowledge bit 0 and returns data 0xFFFF.
- R8: After the last bit the output enable is low and the bus clock is high.
- R9: A write to the access word while its start flag reads 1 is ignored entirely.
- R10: Clearing the enable bit during a frame ends it: the start flag clears, the idle flag sets, and the output enable drops. A start write while disabled stores the fields but leaves the start flag 0.
- R11: Bit 31 of the mode word (offset 2) selects manual mode. In manual mode bit 2 of the pin word (offset 3) drives the bus clock, bit 1 the output enable and bit 0 the data output. Reading offset 3 returns bits 2:1 as written and the data pin level in bit 0. A start write in manual mode leaves the start flag 0, and entering manual mode stops a running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data valid the next cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc_o | output | 1 | Management bus clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input level |

## Verification
Two register writes can land on a frame already in flight: a second start write to the access word, and a write to the control word that clears the enable bit. The bench issues each of these a few dozen cycles into a running frame. It judges the first by checking that the completed access word still shows the original read's address, acknowledge and data. It judges the second by checking that the start flag clears, the idle flag returns and the pins are released long before the frame would have ended. Random reads and writes to a matching and a non-matching PHY address, decoded by a bus-level PHY model in the bench, surround these directed cases.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_ACK     = 47;
  localparam int DATA_FIRST = 48;
  localparam int MIN_DIV    = 3;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_XACT = 2'd1,
    OFS_MODE = 2'd2,
    OFS_PINS = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic       go;
    logic       wr;
    logic       ack;
    logic [4:0] regn;
    logic [4:0] phy;
    logic [15:0] data;
  } xact_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             last_ev
);
  import mdio_pkg::*;
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] eff;
  logic [CW-1:0] half;

  always_comb begin
    eff  = ({1'b0, div} < CW'(MIN_DIV)) ? CW'(MIN_DIV) : {1'b0, div};
    half = (eff + CW'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == eff) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign fall_ev = run && (cnt == '0);
  assign rise_ev = run && (cnt == half);
  assign last_ev = run && (cnt == eff);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= eff));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        abort,
  input  logic        is_wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  regn,
  input  logic [15:0] wdata,
  input  logic        fall_ev,
  input  logic        rise_ev,
  input  logic        last_ev,
  input  logic        mdio_in,
  output logic        busy,
  output logic        mdc,
  output logic        mdo,
  output logic        oe,
  output logic        done,
  output logic        ack,
  output logic [15:0] rdata
);
  import mdio_pkg::*;
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame;
  logic [BW-1:0]         bcnt;
  logic                  wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; mdc <= 1'b1; mdo <= 1'b1; oe <= 1'b0; done <= 1'b0;
      ack <= 1'b0; rdata <= '0; frame <= '0; bcnt <= '0; wr_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        bcnt  <= '0;
        wr_q  <= is_wr;
        ack   <= 1'b0;
        frame <= {32'hFFFF_FFFF, 2'b01, (is_wr ? 2'b01 : 2'b10), phy, regn,
                  (is_wr ? 2'b10 : 2'b11), (is_wr ? wdata : 16'hFFFF)};
      end else if (busy && abort) begin
        busy <= 1'b0; oe <= 1'b0; mdc <= 1'b1;
      end else if (busy) begin
        if (fall_ev) begin
          mdc <= 1'b0;
          mdo <= frame[BW'(FRAME_BITS-1) - bcnt];
          oe  <= wr_q || (bcnt < BW'(TA_FIRST));
        end
        if (rise_ev) begin
          mdc <= 1'b1;
          if (!wr_q && bcnt == BW'(TA_ACK)) ack <= ~mdio_in;
          if (!wr_q && bcnt >= BW'(DATA_FIRST)) rdata <= {rdata[14:0], mdio_in};
        end
        if (last_ev) begin
          if (bcnt == BW'(FRAME_BITS-1)) begin
            busy <= 1'b0; done <= 1'b1; oe <= 1'b0;
          end else begin
            bcnt <= bcnt + BW'(1);
          end
        end
      end
    end
  end

  assert_end_release_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!oe && mdc));
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_read_release_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_q && bcnt > BW'(TA_FIRST)) |-> !oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int          DIV_W   = 16,
  parameter logic [15:0] DIV_RST = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  logic             en_q, manual_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       pins_q;
  xact_t            xa;

  logic fall_ev, rise_ev, last_ev;
  logic eng_busy, eng_mdc, eng_mdo, eng_oe, eng_done, eng_ack;
  logic [15:0] eng_rdata;
  logic xa_accept, start, abort;

  assign xa_accept = bus_wr && (bus_addr == OFS_XACT) && !xa.go;
  assign start     = xa_accept && bus_wdata[31] && en_q && !manual_q && !eng_busy;
  assign abort     = !en_q || manual_q;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(eng_busy), .div(div_q),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .last_ev(last_ev));

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .is_wr(bus_wdata[30]), .phy(bus_wdata[20:16]), .regn(bus_wdata[25:21]),
    .wdata(bus_wdata[15:0]), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .last_ev(last_ev), .mdio_in(mdio_i), .busy(eng_busy), .mdc(eng_mdc),
    .mdo(eng_mdo), .oe(eng_oe), .done(eng_done), .ack(eng_ack),
    .rdata(eng_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; manual_q <= 1'b0; div_q <= DIV_W'(DIV_RST);
      pins_q <= 3'b100; xa <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_CTRL) begin
        en_q  <= bus_wdata[30];
        div_q <= bus_wdata[DIV_W-1:0];
      end
      if (bus_wr && bus_addr == OFS_MODE) manual_q <= bus_wdata[31];
      if (bus_wr && bus_addr == OFS_PINS) pins_q <= bus_wdata[2:0];
      if (xa_accept) begin
        xa.go   <= start;
        xa.wr   <= bus_wdata[30];
        xa.ack  <= 1'b0;
        xa.regn <= bus_wdata[25:21];
        xa.phy  <= bus_wdata[20:16];
        xa.data <= bus_wdata[15:0];
      end else if (eng_done) begin
        xa.go  <= 1'b0;
        xa.ack <= !xa.wr && eng_ack;
        if (!xa.wr) xa.data <= eng_ack ? eng_rdata : 16'hFFFF;
      end else if (xa.go && abort) begin
        xa.go <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_o <= 1'b1; mdio_o <= 1'b1; mdio_oe <= 1'b0; bus_rdata <= '0;
    end else begin
      mdc_o   <= manual_q ? pins_q[2] : eng_mdc;
      mdio_oe <= manual_q ? pins_q[1] : eng_oe;
      mdio_o  <= manual_q ? pins_q[0] : eng_mdo;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CTRL: bus_rdata <= {~eng_busy, en_q, {(30-DIV_W){1'b0}}, div_q};
          OFS_XACT: bus_rdata <= {xa.go, xa.wr, xa.ack, 3'b000, xa.regn[4:1],
                                  xa.regn[0], xa.phy, xa.data} & 32'hE3FF_FFFF;
          OFS_MODE: bus_rdata <= {manual_q, 31'b0};
          default:  bus_rdata <= {29'b0, pins_q[2:1], mdio_i};
        endcase
      end
    end
  end

  assert_go_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(xa.go) |-> eng_busy);
  assert_manual_stop_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(manual_q) && manual_q) |-> !eng_busy);
  assert_disable_stop_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(!en_q) && !en_q) |-> !xa.go);
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam logic [4:0] PHY_A = 5'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc_o, mdio_o, mdio_oe, mdio_i;

  int checks = 0, fails = 0, cyc = 0;
  int pos = 0, base = 0;
  logic [63:0] cap = '0, oecap = '0;
  logic [15:0] phy_mem [32];
  logic resp = 1'b0, drv = 1'b1, man_en = 1'b0, man_val = 1'b1;
  logic [4:0] regl = '0;

  always #4 clk = ~clk;

  mdio_master u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = man_en ? man_val : drv;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // bus-level PHY model
  always @(posedge mdc_o) begin
    cap   <= {cap[62:0], mdio_o};
    oecap <= {oecap[62:0], mdio_oe};
    pos   <= pos + 1;
  end
  always @(negedge mdc_o) begin
    if (pos - base == 46) begin
      resp <= (cap[11:10] == 2'b10) && (cap[9:5] == PHY_A);
      regl <= cap[4:0];
      drv  <= 1'b1;
    end else if (pos - base == 47) drv <= !resp;
    else if (pos - base >= 48 && pos - base < 64)
      drv <= resp ? phy_mem[regl][63 - (pos - base)] : 1'b1;
    else drv <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (!v[31]) break;
    end
  endtask

  function automatic logic [31:0] xword(input logic g, input logic w, input logic a,
                                        input logic [4:0] r, input logic [4:0] p,
                                        input logic [15:0] d);
    return {g, w, a, 3'b000, r, p, d};
  endfunction

  function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  task automatic xact(input logic w, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d);
    logic [31:0] v;
    logic a;
    logic [63:0] ef;
    base = pos;
    wr(2'd1, xword(1'b1, w, 1'b0, r, p, d));
    rd(2'd1, v);
    check("R3 start flag set while busy", {31'b0, v[31]}, 32'd1);
    wait_done();
    ef = exp_frame(w, p, r, d);
    a  = !w && (p == PHY_A);
    check("R7 clock count per frame", pos - base, 64);
    if (w) begin
      check("R5 write frame upper", cap[63:32], ef[63:32]);
      check("R5 write frame lower", cap[31:0], ef[31:0]);
      check("R5 write oe held", oecap[31:0], 32'hFFFF_FFFF);
    end else begin
      check("R4 read header", {14'b0, cap[63:46]}, {14'b0, ef[63:46]});
      check("R4 read header low", {18'b0, cap[45:32]}, {18'b0, ef[45:32]});
      check("R6 read oe pattern", oecap[31:0], 32'hFFFC_0000);
    end
    check("R4 header oe", oecap[63:32], 32'hFFFF_FFFF);
    rd(2'd1, v);
    check(w ? "R5 access word after write" : (a ? "R6 access word after read" : "R7 no-ack read"),
          v, xword(1'b0, w, a, r, p, w ? d : (a ? phy_mem[r] : 16'hFFFF)));
    check("R8 pins released", {30'b0, mdio_oe, mdc_o}, 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    int t0, t1;
    void'($urandom(32'd1357));
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, v); check("R1 control reset", v, 32'h8000_00FF);
    rd(2'd1, v); check("R1 access reset", v, 32'h0);
    check("R2 clock rests high", {31'b0, mdc_o}, 32'd1);

    // disabled start is stored but not started
    wr(2'd1, xword(1'b1, 1'b1, 1'b0, 5'd2, PHY_A, 16'h1234));
    rd(2'd1, v); check("R10 start while disabled", v, xword(1'b0, 1'b1, 1'b0, 5'd2, PHY_A, 16'h1234));

    wr(2'd0, 32'h4000_0003);
    xact(1'b1, PHY_A, 5'd9, 16'hA5C3);
    xact(1'b0, PHY_A, 5'd17, 16'h0);
    xact(1'b0, 5'd30, 5'd4, 16'h0);

    // divider period
    wr(2'd0, 32'h4000_0005);
    base = pos;
    wr(2'd1, xword(1'b1, 1'b1, 1'b0, 5'd1, PHY_A, 16'h0F0F));
    @(posedge mdc_o); t0 = cyc;
    @(posedge mdc_o); t1 = cyc;
    check("R2 period div 5", t1 - t0, 6);
    wait_done();
    wr(2'd0, 32'h4000_0001);
    base = pos;
    wr(2'd1, xword(1'b1, 1'b1, 1'b0, 5'd1, PHY_A, 16'h0F0F));
    @(posedge mdc_o); t0 = cyc;
    @(posedge mdc_o); t1 = cyc;
    check("R2 period clamped", t1 - t0, 4);
    wait_done();
    wr(2'd0, 32'h4000_0003);

    // second start write during a running read
    base = pos;
    wr(2'd1, xword(1'b1, 1'b0, 1'b0, 5'd5, PHY_A, 16'h0));
    repeat (30) @(negedge clk);
    wr(2'd1, xword(1'b1, 1'b1, 1'b0, 5'd7, 5'd12, 16'hBEEF));
    wait_done();
    rd(2'd1, v);
    check("R9 write during frame ignored", v, xword(1'b0, 1'b0, 1'b1, 5'd5, PHY_A, phy_mem[5]));

    // clear enable mid-frame
    base = pos;
    wr(2'd1, xword(1'b1, 1'b1, 1'b0, 5'd3, PHY_A, 16'hFFFF));
    repeat (40) @(negedge clk);
    wr(2'd0, 32'h0000_0003);
    rd(2'd1, v); check("R10 abort clears start", {31'b0, v[31]}, 32'd0);
    rd(2'd0, v); check("R10 abort sets idle", {31'b0, v[31]}, 32'd1);
    check("R10 abort releases pins", {30'b0, mdio_oe, mdc_o}, 32'd1);
    wr(2'd0, 32'h4000_0003);

    // random mix
    for (int k = 0; k < 10; k++) begin
      logic w;
      logic [4:0] p;
      w = 1'($urandom);
      p = ($urandom % 2 == 0) ? PHY_A : 5'($urandom);
      xact(w, p, 5'($urandom), 16'($urandom));
    end

    // manual pin override
    wr(2'd2, 32'h8000_0000);
    wr(2'd3, 32'h0000_0006);
    @(negedge clk);
    check("R11 manual pins", {29'b0, mdc_o, mdio_oe, mdio_o}, 32'd6);
    wr(2'd3, 32'h0000_0001);
    @(negedge clk);
    check("R11 manual pins low clock", {29'b0, mdc_o, mdio_oe, mdio_o}, 32'd1);
    man_en = 1'b1; man_val = 1'b0;
    rd(2'd3, v); check("R11 pin readback low", v, 32'h0);
    man_val = 1'b1;
    rd(2'd3, v); check("R11 pin readback high", v, 32'h1);
    wr(2'd1, xword(1'b1, 1'b0, 1'b0, 5'd2, PHY_A, 16'h0));
    rd(2'd1, v); check("R11 start ignored in manual", {31'b0, v[31]}, 32'd0);
    man_en = 1'b0;
    wr(2'd2, 32'h0);
    @(negedge clk);
    check("R11 leave manual", {30'b0, mdio_oe, mdc_o}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule